// File: doc/BRIEF.md
# Parallel-Port Peripheral Address/Data Front End

This block sits on the peripheral side of an enhanced parallel-port link. It watches three active-low host strobes (write direction, address strobe, data strobe) and tells four host cycle kinds apart: address write, address read, data write and data read. It completes each cycle with a wait/ready handshake. The host cannot start a new cycle until the current one is acknowledged and released, so cycles never overlap.

An address write loads a held address register. That address steers every later data write through a two-stage decode. The upper field picks one of 16 output cards and the lower field picks one of 8 byte registers on that card, which gives 1024 output bits in total. A data write captures the byte and sends it onto a shared internal bus with a one-cycle write strobe and one-hot card and register selects. Read cycles return either the held address or the last data byte written. The bidirectional host data bus is split into an input, an output and an output enable.

Top module: `epp_front`

## Requirements
- R1: After reset, wait_o, bus_oe_o and wr_stb_o are 0, card_sel_o is all zero, and the held address and stored data byte both read back as 0x00.
- R2: A cycle with only n_astb_i low and n_write_i low loads bus_i into the held address register. The load happens on the third rising clock edge after the strobe falls.
- R3: The held address changes only on an accepted address write. Data writes, reads and ignored cycles leave it unchanged.
- R4: A data write (only n_dstb_i low, n_write_i low) raises wr_stb_o for exactly one cycle with wr_data_o = bus_i. In that cycle card_sel_o has only bit addr[6:3] set and reg_sel_o has only bit addr[2:0] set (address bit 7 is not decoded). card_sel_o is all zero whenever wr_stb_o is 0.
- R5: wait_o rises on the third rising edge after a lone strobe falls. It stays high while that strobe is held and falls on the third rising edge after the strobe is released.
- R6: Each strobe assertion is accepted once. Holding a data strobe low for many cycles gives a single wr_stb_o pulse, and a new cycle needs the strobe to be released first.
- R7: If n_astb_i and n_dstb_i are low together, the cycle is ignored: wait_o stays 0, no write strobe is issued, and neither stored register changes.
- R8: bus_oe_o is 1 only during an acknowledged read cycle (n_write_i high when the cycle is accepted), in the same cycles that wait_o is 1. Write cycles never enable it.
- R9: An address read drives the held address on bus_o, and a data read drives the last byte written by a data write.
- R10: Every one of the 16 x 8 card/register combinations (all 1024 output bits) can be reached by one address write followed by one data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_write_i | input | 1 | Host direction strobe, low = host writes |
| n_astb_i | input | 1 | Host address strobe, active low |
| n_dstb_i | input | 1 | Host data strobe, active low |
| bus_i | input | 8 | Host data bus, inbound half |
| bus_o | output | 8 | Host data bus, outbound half |
| bus_oe_o | output | 1 | Outbound bus driver enable |
| wait_o | output | 1 | Handshake, high acknowledges the current strobe |
| wr_stb_o | output | 1 | One-cycle write strobe toward the output cards |
| wr_data_o | output | 8 | Byte carried on the internal output bus |
| card_sel_o | output | 16 | One-hot card select, valid with wr_stb_o |
| reg_sel_o | output | 8 | One-hot register select on the chosen card |

## Verification
The hardest case to reach from the ports is the host asserting both strobes at once. A correct host never does this, and it leaves no trace except an absence of activity. The bench drives both strobes low in the same cycle and holds them for several cycles, so both reach the synchronizer output together. It checks that wait_o and wr_stb_o stay low the whole time. It then issues an address read and a data read to show that neither stored register moved. A strobe held well past its acknowledgement is the second hard case: the bench keeps it low for several cycles and counts the write pulses.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACK   = 2'd1,
    ST_CLASH = 2'd2
  } cyc_st_e;

  typedef struct packed {
    logic is_rd;
    logic is_addr;
  } cyc_kind_t;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic n_write_s_i,
  input  logic n_astb_s_i,
  input  logic n_dstb_s_i,
  output logic addr_we_o,
  output logic data_we_o,
  output logic wait_o,
  output logic rd_oe_o,
  output logic rd_addr_o
);
  cyc_st_e   st_q, st_d;
  cyc_kind_t kind_q, kind_d;
  logic      a_on, d_on, accept;

  assign a_on   = ~n_astb_s_i;
  assign d_on   = ~n_dstb_s_i;
  assign accept = (st_q == ST_IDLE) && (a_on ^ d_on);

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    unique case (st_q)
      ST_IDLE: begin
        if (a_on && d_on) begin
          st_d = ST_CLASH;
        end else if (accept) begin
          st_d           = ST_ACK;
          kind_d.is_rd   = n_write_s_i;
          kind_d.is_addr = a_on;
        end
      end
      ST_ACK, ST_CLASH: if (!a_on && !d_on) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      kind_q <= '0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
    end
  end

  assign addr_we_o = accept && !n_write_s_i && a_on;
  assign data_we_o = accept && !n_write_s_i && d_on;
  assign wait_o    = (st_q == ST_ACK);
  assign rd_oe_o   = (st_q == ST_ACK) && kind_q.is_rd;
  assign rd_addr_o = kind_q.is_addr;

  AST_ONE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_o |=> !data_we_o);  // R6
  AST_OE_WITH_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> wait_o);  // R8
  AST_CLASH_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CLASH) |-> !(addr_we_o || data_we_o || wait_o));  // R7
  AST_WAIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && (a_on || d_on)) |=> wait_o);  // R5
endmodule

// File: rtl/epp_addr_decode.sv
module epp_addr_decode #(
  parameter int CARD_W = 4,
  parameter int REG_W  = 3,
  localparam int NCARD = 1 << CARD_W,
  localparam int NREG  = 1 << REG_W
) (
  input  logic [CARD_W+REG_W-1:0] addr_i,
  input  logic                    en_i,
  output logic [NCARD-1:0]        card_sel_o,
  output logic [NREG-1:0]         reg_sel_o
);
  logic [CARD_W-1:0] card_f;
  logic [REG_W-1:0]  reg_f;

  assign card_f = addr_i[CARD_W+REG_W-1:REG_W];
  assign reg_f  = addr_i[REG_W-1:0];

  // stage 1: card, gated by the write enable
  for (genvar c = 0; c < NCARD; c++) begin : g_card
    assign card_sel_o[c] = en_i && (card_f == CARD_W'(c));
  end
  // stage 2: register within card
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign reg_sel_o[r] = (reg_f == REG_W'(r));
  end
endmodule

// File: rtl/epp_front.sv
module epp_front #(
  parameter int DATA_W      = 8,
  parameter int CARD_W      = 4,
  parameter int REG_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NCARD = 1 << CARD_W,
  localparam int NREG  = 1 << REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              n_write_i,
  input  logic              n_astb_i,
  input  logic              n_dstb_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              wait_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [NCARD-1:0]  card_sel_o,
  output logic [NREG-1:0]   reg_sel_o
);
  logic [2:0]        strb_s;
  logic              addr_we, data_we, rd_addr;
  logic [DATA_W-1:0] addr_q, data_q;
  logic [NCARD-1:0]  card_d;
  logic [NREG-1:0]   reg_d;

  epp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({n_write_i, n_astb_i, n_dstb_i}),
    .q_o   (strb_s)
  );

  epp_cycle_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .n_write_s_i(strb_s[2]),
    .n_astb_s_i (strb_s[1]),
    .n_dstb_s_i (strb_s[0]),
    .addr_we_o  (addr_we),
    .data_we_o  (data_we),
    .wait_o     (wait_o),
    .rd_oe_o    (bus_oe_o),
    .rd_addr_o  (rd_addr)
  );

  epp_addr_decode #(.CARD_W(CARD_W), .REG_W(REG_W)) u_dec (
    .addr_i    (addr_q[CARD_W+REG_W-1:0]),
    .en_i      (data_we),
    .card_sel_o(card_d),
    .reg_sel_o (reg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      data_q     <= '0;
      wr_stb_o   <= 1'b0;
      wr_data_o  <= '0;
      card_sel_o <= '0;
      reg_sel_o  <= '0;
    end else begin
      if (addr_we) addr_q <= bus_i;
      if (data_we) begin
        data_q    <= bus_i;
        wr_data_o <= bus_i;
        reg_sel_o <= reg_d;
      end
      wr_stb_o   <= data_we;
      card_sel_o <= card_d;
    end
  end

  assign bus_o = rd_addr ? addr_q : data_q;

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_we |=> $stable(addr_q));  // R3
  AST_CARD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> ($countones(card_sel_o) == 1));  // R4
  AST_CARD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_o |-> (card_sel_o == '0));  // R4
  AST_REG_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $onehot0(reg_sel_o) && (reg_sel_o != '0));  // R10
endmodule

// File: tb/epp_front_bench.sv
module epp_front_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic n_write = 1'b1, n_astb = 1'b1, n_dstb = 1'b1;
  logic [7:0] bus_in = '0, bus_out, wr_data, reg_sel;
  logic bus_oe, wait_s, wr_stb;
  logic [15:0] card_sel;
  int checks = 0, failures = 0;
  bit done = 0;

  // captured per host cycle
  logic got_wait, got_oe, got_stb, wait_rel2, wait_rel3, oe_rel3;
  logic [7:0] got_bus, got_wdata, got_reg;
  logic [15:0] got_card;
  int stb_cnt;

  always #2 clk = ~clk;

  epp_front u_epp_front (
    .clk_i(clk), .rst_ni(rst_n), .n_write_i(n_write), .n_astb_i(n_astb),
    .n_dstb_i(n_dstb), .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(bus_oe),
    .wait_o(wait_s), .wr_stb_o(wr_stb), .wr_data_o(wr_data),
    .card_sel_o(card_sel), .reg_sel_o(reg_sel)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // is_addr: address strobe else data; is_rd: read else write; hold: extra cycles
  task automatic host_cycle(input bit is_addr, input bit is_rd, input logic [7:0] b, input int hold);
    @(posedge clk); #1;
    n_write = is_rd; bus_in = b;
    @(posedge clk); #1;
    if (is_addr) n_astb = 1'b0; else n_dstb = 1'b0;
    stb_cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    got_wait = wait_s; got_oe = bus_oe; got_bus = bus_out; got_stb = wr_stb;
    got_wdata = wr_data; got_card = card_sel; got_reg = reg_sel;
    if (wr_stb) stb_cnt++;
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); #1;
      if (wr_stb) stb_cnt++;
    end
    n_astb = 1'b1; n_dstb = 1'b1;
    repeat (2) @(posedge clk);
    #1 wait_rel2 = wait_s;
    @(posedge clk); #1;
    wait_rel3 = wait_s; oe_rel3 = bus_oe;
    n_write = 1'b1;
  endtask

  task automatic t_reset;
    #1;
    chk(wait_s == 0 && bus_oe == 0 && wr_stb == 0, "R1 outputs", {wait_s, bus_oe, wr_stb}, 0);
    chk(card_sel == 0, "R1 card_sel", card_sel, 0);
    host_cycle(1, 1, 8'h00, 0);
    chk(got_bus == 8'h00, "R1 addr reset", got_bus, 0);
    host_cycle(0, 1, 8'h00, 0);
    chk(got_bus == 8'h00, "R1 data reset", got_bus, 0);
  endtask

  task automatic t_addr_write;
    host_cycle(1, 0, 8'h5A, 0);
    chk(got_wait == 1, "R2 wait on addr write", got_wait, 1);
    chk(got_oe == 0, "R8 no oe on write", got_oe, 0);
    chk(got_stb == 0, "R2 no wr_stb on addr write", got_stb, 0);
    host_cycle(1, 1, 8'h00, 0);
    chk(got_bus == 8'h5A, "R2 addr loaded", got_bus, 8'h5A);
    chk(got_oe == 1, "R8 oe on addr read", got_oe, 1);
    chk(oe_rel3 == 0, "R8 oe drops on release", oe_rel3, 0);
  endtask

  task automatic t_data_write;
    // addr 0x5A: card = 0xB, reg = 2
    host_cycle(0, 0, 8'hC3, 0);
    chk(got_stb == 1, "R4 wr_stb", got_stb, 1);
    chk(got_wdata == 8'hC3, "R4 wr_data", got_wdata, 8'hC3);
    chk(got_card == 16'h0800, "R4 card_sel", got_card, 16'h0800);
    chk(got_reg == 8'h04, "R4 reg_sel", got_reg, 8'h04);
    chk(stb_cnt == 1, "R4 single pulse", stb_cnt, 1);
    host_cycle(0, 1, 8'h00, 0);
    chk(got_bus == 8'hC3, "R9 data read", got_bus, 8'hC3);
    host_cycle(1, 1, 8'h00, 0);
    chk(got_bus == 8'h5A, "R3 addr kept after data cycles", got_bus, 8'h5A);
    chk(got_stb == 0 && card_sel == 0, "R4 no card_sel on read", {got_stb, card_sel}, 0);
  endtask

  task automatic t_handshake_hold;
    host_cycle(0, 0, 8'h77, 6);
    chk(got_wait == 1, "R5 wait rises third edge", got_wait, 1);
    chk(stb_cnt == 1, "R6 held strobe one pulse", stb_cnt, 1);
    chk(wait_rel2 == 1, "R5 wait held two edges after release", wait_rel2, 1);
    chk(wait_rel3 == 0, "R5 wait falls third edge", wait_rel3, 0);
    host_cycle(0, 0, 8'h78, 0);
    chk(stb_cnt == 1 && got_wdata == 8'h78, "R6 new cycle after release", got_wdata, 8'h78);
  endtask

  task automatic t_clash;
    int stb_seen = 0, wait_seen = 0;
    @(posedge clk); #1;
    n_write = 1'b0; bus_in = 8'hEE; n_astb = 1'b0; n_dstb = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (wr_stb) stb_seen++;
      if (wait_s) wait_seen++;
    end
    n_astb = 1'b1; n_dstb = 1'b1; n_write = 1'b1;
    repeat (4) @(posedge clk);
    chk(wait_seen == 0, "R7 no wait on clash", wait_seen, 0);
    chk(stb_seen == 0, "R7 no wr_stb on clash", stb_seen, 0);
    host_cycle(1, 1, 8'h00, 0);
    chk(got_bus == 8'h5A, "R7 addr unchanged", got_bus, 8'h5A);
    host_cycle(0, 1, 8'h00, 0);
    chk(got_bus == 8'h78, "R7 data unchanged", got_bus, 8'h78);
  endtask

  task automatic t_sweep;
    int bad = 0;
    for (int a = 0; a < 128; a++) begin
      host_cycle(1, 0, 8'(a) | 8'h80, 0);
      host_cycle(0, 0, 8'(a ^ 8'h3C), 0);
      if (got_card != (16'h1 << (a >> 3)) || got_reg != (8'h1 << (a & 7))
          || got_wdata != 8'(a ^ 8'h3C) || stb_cnt != 1) begin
        bad++;
        chk(0, "R10 sweep decode", {got_card, got_reg}, {16'h1 << (a >> 3), 8'h1 << (a & 7)});
      end
    end
    chk(bad == 0, "R10 all 128 registers reached", bad, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_addr_write();
    t_data_write();
    t_handshake_hold();
    t_clash();
    t_sweep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule